// File: doc/BRIEF.md
# Unified Funnel Shift Unit

This block shifts or rotates an N-bit operand by 0 to N-1 positions, in either direction, with logical, arithmetic or rotate semantics. All six operations go through one datapath. A front end builds a 2N-bit word from the operand and a window offset. A shared core then extracts an N-bit contiguous window from that word through a cascade of 2:1 multiplexer stages. Each bit of the offset drives one stage directly, so the amount needs no decoding.

Right operations place the operand in the lower half of the word. The upper half is filled according to the kind of operation, and the window starts at the shift amount. Left operations place the operand in the upper half and use a window offset of N minus the amount. An optional output register, selected by a parameter, adds one cycle of latency. It has a synchronous, active-high reset.

Top module: `fsh_unit`

## Requirements
- R1: With the output register enabled (the default), `result_o` shows the result for the inputs sampled at a rising clock edge, one edge later. A high `rst` at an edge clears `result_o` to zero, and reset takes priority over any operation presented at that edge.
- R2: The operation code `op_i[0]` selects direction (1 = right, 0 = left) and `op_i[2:1]` selects kind (00 logical, 01 arithmetic, 10 rotate). A logical right shift by k fills the top k result bits with zeros.
- R3: An arithmetic right shift (op 3'b011) by k fills the top k result bits with copies of operand bit N-1.
- R4: A logical left shift (op 3'b000) by k moves operand bit j to result bit j+k and fills the low k bits with zeros.
- R5: An arithmetic left shift (op 3'b010) gives exactly the same result as the logical left shift.
- R6: A rotate (op 3'b100 left, 3'b101 right) by k wraps the bits that leave one end into the other end, so no bit is lost.
- R7: A shift amount of zero returns the operand unchanged for every operation code.
- R8: The kind code 11 (op 3'b110 and 3'b111) behaves as the logical shift in the direction given by `op_i[0]`.
- R9: N must be a power of two and at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| operand_i | input | N | Value to shift |
| amount_i | input | log2(N) | Shift distance, 0 to N-1 |
| op_i | input | 3 | Operation: bit 0 direction, bits 2:1 kind |
| result_o | output | N | Shifted or rotated value |

## Verification
The synchronous reset and a new operation can land on the same clock edge. Reset must win there, and the unit must recover cleanly afterwards. The bench provokes this by holding a nonzero rotate operation on the inputs while raising `rst` for one edge. It expects a zero result after that edge. It then expects the correct rotate result one edge after `rst` falls, while the inputs are unchanged. Every operation code is also swept over every shift amount, with random operands, all-ones operands and sign-bit-only operands, against a model built from the language shift operators.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
   typedef enum logic [1:0] {
      KIND_LOGIC = 2'b00,
      KIND_ARITH = 2'b01,
      KIND_ROTATE = 2'b10,
      KIND_SPARE = 2'b11
   } shift_kind_e;

   function automatic shift_kind_e kind_of(input logic [2:0] op);
      return shift_kind_e'(op[2:1]);
   endfunction

   function automatic logic is_right(input logic [2:0] op);
      return op[0];
   endfunction
endpackage

// File: rtl/fsh_frontend.sv
module fsh_frontend
   import fsh_pkg::*;
#(
   parameter int N = 32,
   localparam int LOG2N = $clog2(N),
   localparam int OFFW = LOG2N + 1
) (
   input  logic [N-1:0]     operand_i,
   input  logic [LOG2N-1:0] amount_i,
   input  logic [2:0]       op_i,
   output logic [2*N-1:0]   word_o,
   output logic [OFFW-1:0]  offset_o
);
   localparam logic [OFFW-1:0] FULL = OFFW'(N);

   shift_kind_e kind;
   logic [N-1:0] fill;

   assign kind = kind_of(op_i);

   always_comb begin
      fill = '0;
      if (is_right(op_i)) begin
         unique case (kind)
            KIND_ARITH:  fill = {N{operand_i[N-1]}};
            KIND_ROTATE: fill = operand_i;
            default:     fill = '0;
         endcase
         word_o   = {fill, operand_i};
         offset_o = {1'b0, amount_i};
      end else begin
         if (kind == KIND_ROTATE) fill = operand_i;
         word_o   = {operand_i, fill};
         offset_o = FULL - {1'b0, amount_i};
      end
   end
endmodule

// File: rtl/fsh_funnel_core.sv
module fsh_funnel_core #(
   parameter int N = 32,
   localparam int LOG2N = $clog2(N),
   localparam int OFFW = LOG2N + 1
) (
   input  logic [2*N-1:0]  word_i,
   input  logic [OFFW-1:0] offset_i,
   output logic [N-1:0]    window_o
);
   logic [2*N-1:0] stage [0:LOG2N];

   assign stage[0] = word_i;

   for (genvar i = 0; i < LOG2N; i++) begin : g_stage
      assign stage[i+1] = offset_i[i] ? (stage[i] >> (2**i)) : stage[i];
   end

   assign window_o = offset_i[LOG2N] ? stage[LOG2N][2*N-1:N] : stage[LOG2N][N-1:0];
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
   import fsh_pkg::*;
#(
   parameter int N = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int LOG2N = $clog2(N),
   localparam int OFFW = LOG2N + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N-1:0]     operand_i,
   input  logic [LOG2N-1:0] amount_i,
   input  logic [2:0]       op_i,
   output logic [N-1:0]     result_o
);
   // R9: elaboration-time parameter checks
   if (N < 2 || (1 << LOG2N) != N) begin : g_bad_width
      $error("fsh_unit: N must be a power of two, at least 2");
   end

   logic [2*N-1:0]  word;
   logic [OFFW-1:0] offset;
   logic [N-1:0]    res_c;

   fsh_frontend #(.N(N)) front_i (
      .operand_i(operand_i),
      .amount_i (amount_i),
      .op_i     (op_i),
      .word_o   (word),
      .offset_o (offset)
   );

   fsh_funnel_core #(.N(N)) core_i (
      .word_i  (word),
      .offset_i(offset),
      .window_o(res_c)
   );

   if (REG_OUT) begin : g_reg
      logic [N-1:0] res_q;
      always_ff @(posedge clk) begin
         if (rst) res_q <= '0;
         else     res_q <= res_c;
      end
      assign result_o = res_q;

      assert_reset_R1: assert property (@(posedge clk) rst |=> result_o == '0);
      assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
         !rst |=> result_o == $past(res_c));
   end else begin : g_comb
      assign result_o = res_c;
   end

   assert_lsr_top_R2: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'b001 && amount_i != '0) |-> res_c[N-1] == 1'b0);
   assert_asr_sign_R3: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'b011) |-> res_c[N-1] == operand_i[N-1]);
   assert_lsl_low_R4: assert property (@(posedge clk) disable iff (rst)
      (op_i[0] == 1'b0 && op_i[2:1] != 2'b10 && amount_i != '0) |-> res_c[0] == 1'b0);
   assert_rot_keep_R6: assert property (@(posedge clk) disable iff (rst)
      (op_i[2:1] == 2'b10) |-> $countones(res_c) == $countones(operand_i));
   assert_zero_amt_R7: assert property (@(posedge clk) disable iff (rst)
      (amount_i == '0) |-> res_c == operand_i);
endmodule

// File: tb/fsh_unit_tb_top.sv
`timescale 1ns/1ps
module fsh_unit_tb_top;
   localparam int N = 32;
   localparam int LOG2N = $clog2(N);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] operand = '0;
   logic [LOG2N-1:0] amount = '0;
   logic [2:0] op = '0;
   logic [N-1:0] result;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   fsh_unit #(.N(N), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst(rst), .operand_i(operand), .amount_i(amount),
      .op_i(op), .result_o(result)
   );

   function automatic logic [N-1:0] model(input logic [N-1:0] x, input int k,
                                          input logic [2:0] o);
      logic [N-1:0] r;
      case (o)
         3'b001, 3'b111: r = x >> k;
         3'b011:         r = $signed(x) >>> k;
         3'b101:         r = (x >> k) | (x << (N - k));
         3'b100:         r = (x << k) | (x >> (N - k));
         default:        r = x << k;
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic [2:0] o, input int k);
      if (k == 0) return "R7";
      case (o)
         3'b001: return "R2";
         3'b011: return "R3";
         3'b000: return "R4";
         3'b010: return "R5";
         3'b100, 3'b101: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp,
                        input logic [2:0] o, input int k);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s op=%b k=%0d actual=%h expected=%h", req, o, k, act, exp);
      end
   endtask

   task automatic apply(input logic [N-1:0] x, input int k, input logic [2:0] o);
      @(negedge clk);
      operand = x;
      amount = LOG2N'(k);
      op = o;
      @(negedge clk);
      check(req_of(o, k), result, model(x, k, o), o, k);
   endtask

   task automatic t_reset_state;
      operand = 32'hDEAD_BEEF;
      amount = 5'd3;
      op = 3'b101;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", result, '0, op, 3);
      rst = 1'b0;
   endtask

   task automatic t_sweep(input logic [N-1:0] x);
      for (int o = 0; o < 8; o++)
         for (int k = 0; k < N; k++)
            apply(x, k, 3'(o));
   endtask

   task automatic t_arith_left_matches;
      logic [N-1:0] x;
      logic [N-1:0] a;
      for (int k = 0; k < N; k += 3) begin
         x = $urandom;
         apply(x, k, 3'b010);
         a = result;
         apply(x, k, 3'b000);
         check("R5", a, result, 3'b010, k);
      end
   endtask

   task automatic t_reset_collision;
      @(negedge clk);
      operand = 32'h8000_0001;
      amount = 5'd4;
      op = 3'b100;
      rst = 1'b1;
      @(negedge clk);
      check("R1", result, '0, op, 4);
      rst = 1'b0;
      @(negedge clk);
      check("R1", result, 32'h0000_0018, op, 4);
   endtask

   task automatic run_all;
      t_reset_state();
      t_sweep(32'hFFFF_FFFF);
      t_sweep(32'h8000_0000);
      for (int n = 0; n < 4; n++) t_sweep($urandom);
      t_arith_left_matches();
      t_reset_collision();
   endtask

   initial begin
      fork
         run_all();
         begin
            #1_000_000;
            bad++;
            total++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule